// File: doc/BRIEF.md
# In-Order Memory Response Reorder Buffer

This block sits between a queue of pending global memory operations and a register writeback port. It takes requests one at a time from the head of an issue queue, each carrying a sequence number and an operation kind (load, store, atomic or fence). It forwards them to memory, subject to a cap on how many loads and how many stores may be in flight. It accepts completions tagged with the sequence number of the request they answer. It then offers finished requests to a downstream consumer over a valid/ready handshake.

A static mode input selects the delivery policy. In in-order mode, a slot is reserved at issue time in a circular buffer. Only the oldest reserved slot may be delivered, and only after its completion has arrived. In out-of-order mode, completions go into a load FIFO or a store FIFO, and loads are always offered first. Fences take no slot in either mode, because nothing ever comes back for them.

The mode must only change while the block is empty.

Top module: `mem_resp_orderer`

## Requirements
- R1: Loads (kind 0) and atomics (kind 2) share one in-flight count, stores (kind 1) have their own count, and fences (kind 3) are counted in neither; each count never exceeds LIMIT, and a full read count does not block a store or a fence.
- R2: When the head request's count equals LIMIT, `iss_ready` is low and the head waits; a retirement in the same cycle does not lift the stall in that cycle.
- R3: A count rises when a request of its class is forwarded and falls when that request is retired by a delivery handshake, so a request stalled by R2 is accepted in the cycle after the handshake.
- R4: With `in_order`=1, every non-fence request takes a buffer slot when forwarded; when all DEPTH slots are held, a load or store stalls while a fence is still accepted.
- R5: With `in_order`=1, a completion marks its slot done. `dlv_valid` is raised only for the oldest slot, and only once that slot is done (one cycle after the completion); younger finished slots wait.
- R6: A handshake (`dlv_valid` and `dlv_ready` both high) retires the offered entry, and the next candidate is offered from the following cycle. While `dlv_ready` is low in in-order mode, the offer holds unchanged.
- R7: With `in_order`=0, load and atomic completions go to a load FIFO and store completions go to a store FIFO; delivery offers the load FIFO head whenever that FIFO is non-empty, and otherwise the store FIFO head.
- R8: `err` is high for one cycle, one cycle after any of these: a completion with no reserved slot, a completion for a slot already done, or a completion of kind 3.
- R9: After reset, no request is outstanding: `iss_ready` is high, and both `dlv_valid` and `err` are low.
- R10: `mem_valid` equals `iss_valid && iss_ready` in the same cycle, with `mem_seq` and `mem_kind` copying the issue fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_order | input | 1 | 1 = in-order delivery, 0 = out-of-order delivery |
| iss_valid | input | 1 | Head of issue queue is present |
| iss_seq | input | SEQ_W | Sequence number of the head request |
| iss_kind | input | 2 | 0 load, 1 store, 2 atomic, 3 fence |
| iss_ready | output | 1 | Head request may be forwarded this cycle |
| mem_valid | output | 1 | Request forwarded to memory |
| mem_seq | output | SEQ_W | Sequence number forwarded |
| mem_kind | output | 2 | Kind forwarded |
| rsp_valid | input | 1 | Completion arrives from memory |
| rsp_seq | input | SEQ_W | Sequence number of the completion |
| rsp_kind | input | 2 | Kind of the completed request |
| dlv_valid | output | 1 | An entry is offered for writeback |
| dlv_ready | input | 1 | Consumer takes the offered entry |
| dlv_seq | output | SEQ_W | Sequence number of the offered entry |
| dlv_kind | output | 2 | Kind of the offered entry |
| err | output | 1 | One-cycle protocol error pulse |

## Verification
The sharpest collision is a retirement at the delivery port in the same cycle as a new request at the issue port, while the counter is at its cap. The bench fills the read class to its cap and completes the oldest load. It then raises `dlv_ready` and presents a further load in the same cycle, and expects `iss_ready` low in that cycle and high in the next. A second overlap, a completion landing in the load FIFO while a store is already on offer, is judged by the offer switching to the load in the cycle after that completion.

// File: rtl/mro_pkg.sv
package mro_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_ATOMIC = 2'd2,
    OP_FENCE  = 2'd3
  } op_kind_e;

  // Loads and atomics share the read in-flight class.
  function automatic logic is_rd_class(input op_kind_e k);
    return (k == OP_LOAD) || (k == OP_ATOMIC);
  endfunction

  function automatic logic is_wr_class(input op_kind_e k);
    return k == OP_STORE;
  endfunction

  function automatic logic is_fence(input op_kind_e k);
    return k == OP_FENCE;
  endfunction

endpackage

// File: rtl/mro_class_ctr.sv
module mro_class_ctr #(
  parameter int LIMIT = 4,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic          at_limit,
  output logic          underflow,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)                          count <= '0;
    else if (inc && !dec)                count <= count + 1'b1;
    else if (dec && !inc && count != '0) count <= count - 1'b1;
  end

  assign at_limit  = (count >= CW'(LIMIT));
  assign underflow = dec && !inc && (count == '0);

  AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(LIMIT)); // R1
  AST_INC_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_limit); // R2

endmodule

// File: rtl/mro_fifo.sv
module mro_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [PW:0]   cnt;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wrap_inc(wp);
      if (pop)  rp <= wrap_inc(rp);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == (PW+1)'(DEPTH));

  AST_FIFO_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R7
  AST_FIFO_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop)); // R7

endmodule

// File: rtl/mro_order_buf.sv
module mro_order_buf #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 6,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [SEQ_W-1:0] alloc_seq,
  input  logic [1:0]       alloc_kind,
  input  logic             mark,
  input  logic [SEQ_W-1:0] mark_seq,
  output logic             mark_miss,
  output logic             mark_dup,
  input  logic             retire,
  output logic             head_ready,
  output logic [SEQ_W-1:0] head_seq,
  output logic [1:0]       head_kind,
  output logic             full,
  output logic             empty
);

  logic [DEPTH-1:0] vld, done, hit;
  logic [SEQ_W-1:0] seq_q  [DEPTH];
  logic [1:0]       kind_q [DEPTH];
  logic [PW-1:0]    hd, tl;
  logic [PW:0]      occ;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Associative lookup of the completing sequence number.
  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign hit[i] = vld[i] && (seq_q[i] == mark_seq);
  end

  assign mark_miss = mark && (hit == '0);
  assign mark_dup  = mark && ((hit & done) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; done <= '0; hd <= '0; tl <= '0; occ <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (mark && hit[i]) done[i] <= 1'b1;
      if (retire) begin
        vld[hd] <= 1'b0;
        hd      <= wrap_inc(hd);
      end
      if (alloc) begin
        vld[tl]  <= 1'b1;
        done[tl] <= 1'b0;
        tl       <= wrap_inc(tl);
      end
      if (alloc && !retire)      occ <= occ + 1'b1;
      else if (retire && !alloc) occ <= occ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      seq_q[tl]  <= alloc_seq;
      kind_q[tl] <= alloc_kind;
    end
  end

  assign head_ready = vld[hd] && done[hd];
  assign head_seq   = seq_q[hd];
  assign head_kind  = kind_q[hd];
  assign full       = (occ == (PW+1)'(DEPTH));
  assign empty      = (occ == '0);

  AST_RETIRE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> head_ready); // R5
  AST_ALLOC_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full); // R4
  AST_FIRST_IS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && empty) |=> (head_seq == $past(alloc_seq))); // R6

endmodule

// File: rtl/mem_resp_orderer.sv
module mem_resp_orderer #(
  parameter int DEPTH = 8,
  parameter int LIMIT = 4,
  parameter int SEQ_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_order,
  input  logic             iss_valid,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic [1:0]       iss_kind,
  output logic             iss_ready,
  output logic             mem_valid,
  output logic [SEQ_W-1:0] mem_seq,
  output logic [1:0]       mem_kind,
  input  logic             rsp_valid,
  input  logic [SEQ_W-1:0] rsp_seq,
  input  logic [1:0]       rsp_kind,
  output logic             dlv_valid,
  input  logic             dlv_ready,
  output logic [SEQ_W-1:0] dlv_seq,
  output logic [1:0]       dlv_kind,
  output logic             err
);
  import mro_pkg::*;

  localparam int CW = $clog2(LIMIT + 1);
  localparam int EW = SEQ_W + 2;

  // Named internal events.
  logic          iss_rd, iss_wr, iss_fn, rsp_rd, rsp_wr, rsp_fn;
  logic          rd_at_lim, wr_at_lim, rd_under, wr_under;
  logic [CW-1:0] rd_cnt, wr_cnt;
  logic          iss_fire, dlv_fire, ob_alloc, ob_mark, ob_retire;
  logic          ob_miss, ob_dup, ob_ready, ob_full, ob_empty;
  logic [SEQ_W-1:0] ob_seq;
  logic [1:0]    ob_kind;
  logic          ldq_push, stq_push, ldq_pop, stq_pop;
  logic          ldq_empty, stq_empty, ldq_full, stq_full;
  logic [EW-1:0] ldq_dout, stq_dout;
  logic          class_stall, room_stall, err_next;

  assign iss_rd = is_rd_class(op_kind_e'(iss_kind));
  assign iss_wr = is_wr_class(op_kind_e'(iss_kind));
  assign iss_fn = is_fence(op_kind_e'(iss_kind));
  assign rsp_rd = is_rd_class(op_kind_e'(rsp_kind));
  assign rsp_wr = is_wr_class(op_kind_e'(rsp_kind));
  assign rsp_fn = is_fence(op_kind_e'(rsp_kind));

  // Issue throttling: registered counts only, no same-cycle release.
  assign class_stall = (iss_rd && rd_at_lim) || (iss_wr && wr_at_lim);
  assign room_stall  = in_order ? (!iss_fn && ob_full)
                                : ((iss_rd && ldq_full) || (iss_wr && stq_full));
  assign iss_ready   = !class_stall && !room_stall;
  assign iss_fire    = iss_valid && iss_ready;

  assign mem_valid = iss_fire;
  assign mem_seq   = iss_seq;
  assign mem_kind  = iss_kind;

  // Completion routing.
  assign ob_alloc = iss_fire && in_order && !iss_fn;
  assign ob_mark  = rsp_valid && in_order && !rsp_fn;
  assign ldq_push = rsp_valid && !in_order && rsp_rd && (!ldq_full || ldq_pop);
  assign stq_push = rsp_valid && !in_order && rsp_wr && (!stq_full || stq_pop);

  // Delivery selection.
  always_comb begin
    if (in_order) begin
      dlv_valid = ob_ready;
      dlv_seq   = ob_seq;
      dlv_kind  = ob_kind;
    end else if (!ldq_empty) begin
      dlv_valid = 1'b1;
      {dlv_seq, dlv_kind} = ldq_dout;
    end else begin
      dlv_valid = !stq_empty;
      {dlv_seq, dlv_kind} = stq_dout;
    end
  end

  assign dlv_fire  = dlv_valid && dlv_ready;
  assign ob_retire = dlv_fire && in_order;
  assign ldq_pop   = dlv_fire && !in_order && !ldq_empty;
  assign stq_pop   = dlv_fire && !in_order && ldq_empty;

  mro_class_ctr #(.LIMIT(LIMIT)) u_rd_ctr (
    .clk(clk), .rst_n(rst_n),
    .inc(iss_fire && iss_rd),
    .dec(dlv_fire && is_rd_class(op_kind_e'(dlv_kind))),
    .at_limit(rd_at_lim), .underflow(rd_under), .count(rd_cnt));

  mro_class_ctr #(.LIMIT(LIMIT)) u_wr_ctr (
    .clk(clk), .rst_n(rst_n),
    .inc(iss_fire && iss_wr),
    .dec(dlv_fire && is_wr_class(op_kind_e'(dlv_kind))),
    .at_limit(wr_at_lim), .underflow(wr_under), .count(wr_cnt));

  mro_order_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_obuf (
    .clk(clk), .rst_n(rst_n),
    .alloc(ob_alloc), .alloc_seq(iss_seq), .alloc_kind(iss_kind),
    .mark(ob_mark), .mark_seq(rsp_seq), .mark_miss(ob_miss), .mark_dup(ob_dup),
    .retire(ob_retire), .head_ready(ob_ready), .head_seq(ob_seq),
    .head_kind(ob_kind), .full(ob_full), .empty(ob_empty));

  mro_fifo #(.DEPTH(LIMIT), .W(EW)) u_ldq (
    .clk(clk), .rst_n(rst_n), .push(ldq_push), .din({rsp_seq, rsp_kind}),
    .pop(ldq_pop), .dout(ldq_dout), .empty(ldq_empty), .full(ldq_full));

  mro_fifo #(.DEPTH(LIMIT), .W(EW)) u_stq (
    .clk(clk), .rst_n(rst_n), .push(stq_push), .din({rsp_seq, rsp_kind}),
    .pop(stq_pop), .dout(stq_dout), .empty(stq_empty), .full(stq_full));

  // Error pulse: unmatched or repeated completion, fence completion,
  // completion into a full FIFO, or counter underflow.
  assign err_next = (ob_mark && (ob_miss || ob_dup))
                  || (rsp_valid && rsp_fn)
                  || (rsp_valid && !in_order && rsp_rd && ldq_full && !ldq_pop)
                  || (rsp_valid && !in_order && rsp_wr && stq_full && !stq_pop)
                  || rd_under || wr_under;

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err_next;
  end

  AST_STALL_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_rd && rd_cnt == CW'(LIMIT)) |-> !iss_ready); // R2
  AST_LOADS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_order && !ldq_empty) |-> (dlv_valid && is_rd_class(op_kind_e'(dlv_kind)))); // R7
  AST_OFFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_order && dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_seq))); // R6
  AST_FWD_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> iss_valid); // R10
  AST_FENCE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_fire && iss_fn) |=> (rd_cnt <= $past(rd_cnt) && wr_cnt <= $past(wr_cnt))); // R1
  AST_EMPTY_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_order && ob_empty) |-> !dlv_valid); // R5

endmodule

// File: tb/sim_mem_resp_orderer.sv
`timescale 1ns/1ps
module sim_mem_resp_orderer;
  localparam int DEPTH = 4;
  localparam int LIMIT = 3;
  localparam int SEQ_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_order = 1'b1;
  logic iss_valid = 1'b0;
  logic [SEQ_W-1:0] iss_seq = '0;
  logic [1:0] iss_kind = '0;
  logic iss_ready, mem_valid;
  logic [SEQ_W-1:0] mem_seq;
  logic [1:0] mem_kind;
  logic rsp_valid = 1'b0;
  logic [SEQ_W-1:0] rsp_seq = '0;
  logic [1:0] rsp_kind = '0;
  logic dlv_valid;
  logic dlv_ready = 1'b0;
  logic [SEQ_W-1:0] dlv_seq;
  logic [1:0] dlv_kind;
  logic err;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mem_resp_orderer #(.DEPTH(DEPTH), .LIMIT(LIMIT), .SEQ_W(SEQ_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_order(in_order),
    .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_kind(iss_kind),
    .iss_ready(iss_ready), .mem_valid(mem_valid), .mem_seq(mem_seq),
    .mem_kind(mem_kind), .rsp_valid(rsp_valid), .rsp_seq(rsp_seq),
    .rsp_kind(rsp_kind), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_seq(dlv_seq), .dlv_kind(dlv_kind), .err(err));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Present one request for one cycle; caller stands just after a falling edge.
  task automatic issue(input int s, input int k, input bit acc, input string tag);
    iss_valid = 1'b1; iss_seq = SEQ_W'(s); iss_kind = 2'(k);
    #1;
    chk(iss_ready == acc, tag, int'(iss_ready), int'(acc));
    if (acc)
      chk(mem_valid && mem_seq == SEQ_W'(s) && mem_kind == 2'(k),
          "R10 forward", int'(mem_seq), s);
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic respond(input int s, input int k);
    rsp_valid = 1'b1; rsp_seq = SEQ_W'(s); rsp_kind = 2'(k);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic take(input int s, input int k, input string tag);
    #1;
    chk(dlv_valid == 1'b1, tag, int'(dlv_valid), 1);
    chk(dlv_seq == SEQ_W'(s) && dlv_kind == 2'(k), tag, int'(dlv_seq), s);
    dlv_ready = 1'b1;
    @(negedge clk);
    dlv_ready = 1'b0;
  endtask

  task automatic no_offer(input string tag);
    #1;
    chk(dlv_valid == 1'b0, tag, int'(dlv_valid), 0);
  endtask

  task automatic t_reset;
    #1;
    chk(iss_ready == 1'b1, "R9 ready after reset", int'(iss_ready), 1);
    chk(dlv_valid == 1'b0, "R9 no offer after reset", int'(dlv_valid), 0);
    chk(err == 1'b0, "R9 err low after reset", int'(err), 0);
  endtask

  task automatic t_in_order;
    issue(1, 0, 1'b1, "R4 load reserves");
    issue(2, 1, 1'b1, "R4 store reserves");
    issue(3, 0, 1'b1, "R4 load reserves");
    respond(3, 0);
    respond(2, 1);
    no_offer("R5 younger done entries wait");
    respond(1, 0);
    take(1, 0, "R5 oldest offered once done");
    take(2, 1, "R6 next oldest after retire");
    take(3, 0, "R6 last entry");
    no_offer("R6 drained");
  endtask

  task automatic t_hold_and_fence;
    issue(10, 3, 1'b1, "R4 fence accepted");
    issue(11, 2, 1'b1, "R1 atomic accepted");
    respond(11, 2);
    #1;
    chk(dlv_valid && dlv_seq == SEQ_W'(11), "R6 offer before ready", int'(dlv_seq), 11);
    @(negedge clk);
    #1;
    chk(dlv_valid && dlv_seq == SEQ_W'(11), "R6 offer held while not ready", int'(dlv_seq), 11);
    take(11, 2, "R4 fence left no slot");
    no_offer("R4 fence produced no entry");
  endtask

  task automatic t_caps;
    issue(20, 0, 1'b1, "R1 load 1");
    issue(21, 2, 1'b1, "R1 atomic shares class");
    issue(22, 0, 1'b1, "R1 load 3");
    issue(23, 0, 1'b0, "R2 read class at cap stalls");
    issue(23, 1, 1'b1, "R1 store not blocked by read cap");
    issue(24, 1, 1'b0, "R4 buffer full stalls store");
    issue(25, 3, 1'b1, "R4 fence passes full buffer");
    respond(20, 0);
    // Same cycle: retire oldest load and present another load.
    iss_valid = 1'b1; iss_seq = SEQ_W'(26); iss_kind = 2'd0; dlv_ready = 1'b1;
    #1;
    chk(dlv_valid && dlv_seq == SEQ_W'(20), "R6 oldest offered", int'(dlv_seq), 20);
    chk(iss_ready == 1'b0, "R2 no release in retire cycle", int'(iss_ready), 0);
    @(negedge clk);
    dlv_ready = 1'b0;
    #1;
    chk(iss_ready == 1'b1, "R3 released after retire", int'(iss_ready), 1);
    @(negedge clk);
    iss_valid = 1'b0;
    respond(26, 0);
    respond(22, 0);
    respond(21, 2);
    respond(23, 1);
    take(21, 2, "R5 order 21");
    take(22, 0, "R5 order 22");
    take(23, 1, "R5 order 23");
    take(26, 0, "R5 order 26");
    no_offer("R6 caps drained");
  endtask

  task automatic t_out_of_order;
    in_order = 1'b0;
    @(negedge clk);
    issue(30, 1, 1'b1, "R7 store issued");
    issue(31, 0, 1'b1, "R7 load issued");
    issue(32, 1, 1'b1, "R7 store issued");
    issue(33, 2, 1'b1, "R7 atomic issued");
    respond(30, 1);
    #1;
    chk(dlv_valid && dlv_seq == SEQ_W'(30), "R7 store offered alone", int'(dlv_seq), 30);
    respond(31, 0);
    #1;
    chk(dlv_valid && dlv_seq == SEQ_W'(31), "R7 load preempts store", int'(dlv_seq), 31);
    respond(33, 2);
    respond(32, 1);
    take(31, 0, "R7 load fifo first");
    take(33, 2, "R7 atomic in load fifo");
    take(30, 1, "R7 store fifo order");
    take(32, 1, "R7 store fifo order 2");
    no_offer("R7 drained");
    chk(err == 1'b0, "R8 no error in clean run", int'(err), 0);
    in_order = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_errors;
    respond(50, 0);
    #1;
    chk(err == 1'b1, "R8 unmatched completion", int'(err), 1);
    @(negedge clk);
    #1;
    chk(err == 1'b0, "R8 pulse is one cycle", int'(err), 0);
    issue(51, 0, 1'b1, "R8 setup load");
    respond(51, 0);
    #1;
    chk(err == 1'b0, "R8 first completion clean", int'(err), 0);
    respond(51, 0);
    #1;
    chk(err == 1'b1, "R8 duplicate completion", int'(err), 1);
    take(51, 0, "R8 entry still delivered");
    respond(52, 3);
    #1;
    chk(err == 1'b1, "R8 fence completion", int'(err), 1);
    no_offer("R8 fence completion made no entry");
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_in_order();
    t_hold_and_fence();
    t_caps();
    t_out_of_order();
    t_errors();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule